// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Software Bypass

This block is a small direct-mapped data cache placed between one processor and a shared memory bus in a multiprocessor system that has no hardware coherence. Every store is written through to memory, so the cache never holds data that memory lacks. Consistency of shared data is left to software. Software can route all accesses around the cache, or only the accesses to selected pages. A spin-lock instruction marked as interlocked always goes around the cache.

An access that goes around the cache also clears any cached copy of the same word, so a later cached read cannot return an old value. A read that hits completes in the cycle it is presented. Every other access stalls the processor until memory acknowledges it. The read and write halves of an interlocked read-modify-write hold the bus locked against other masters for the whole operation.

Top module: `wt_cache`

## Requirements
- R1: After a synchronous active-low reset every line is invalid. `mem_req`, `mem_lock` and `cpu_ready` are low while no access is presented.
- R2: A read to a valid line whose tag matches, without bypass, raises `cpu_ready` in the cycle it is presented with the cached word on `cpu_rdata`. No memory request is made.
- R3: A read that misses and is not bypassed issues one memory read. It stalls until `mem_ack`, returns `mem_rdata` in the acknowledge cycle and fills the line, so the next read of that word hits.
- R4: Every write becomes a memory write with `mem_we` high and completes on `mem_ack`. A write hit that is not bypassed also updates the cached word. A write miss leaves the cache unchanged, so a later read of that word misses.
- R5: An access is bypassed when the global bypass input is high, or when bit `cpu_page` of the page bypass map is high, or when `cpu_lock` is high.
- R6: A bypassed read always goes to memory, returns the memory word and does not fill the cache.
- R7: A bypassed read or write to a word whose line is valid with a matching tag invalidates that line, so the next non-bypassed read of the word misses and refetches it.
- R8: `mem_lock` rises when an interlocked read is accepted. It stays high across the idle cycles before the interlocked write and falls in the cycle after that write's `mem_ack`.
- R9: While `mem_req` is high and no acknowledge has arrived, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R10: The line index is the low `log2(LINES)` bits of the word address and the tag is the remaining bits. A fill for a different tag at the same index evicts the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | Read strobe, held until `cpu_ready` |
| cpu_wr | input | 1 | Write strobe, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_lock | input | 1 | Access belongs to the interlocked read-modify-write |
| cpu_page | input | PAGE_W | Page number of the access |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| byp_all | input | 1 | Global bypass enable |
| byp_page_map | input | PAGES | Per-page bypass bitmap |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_lock | output | 1 | Bus locked for interlocked operation |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
Reads are tried cold, warm, and against a second tag at the same index. These patterns separate the single-cycle hit path from the stalled refill path and show that a line is evicted. The bench changes memory behind the cache and then reads the same word three ways: cached, page-bypassed and globally bypassed. A stale hit, a bypass that returns fresh data, and a later refetch each tell whether bypass routing and invalidation work. Write hits, write misses and bypassed writes show update against no-allocate against invalidate. An interlocked pair with idle cycles between its halves checks that the bus lock spans the whole operation. Memory latencies of zero, two and five cycles check that the stall length follows the acknowledge.

// File: rtl/wt_cache_pkg.sv
`timescale 1ns/1ps
// Shared types for the write-through cache.
package wt_cache_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,  // waiting for an access; hits complete here
        ST_BUSY = 1'b1   // memory request outstanding
    } ctrl_state_e;
endpackage

// File: rtl/wt_cache_bypass_sel.sv
`timescale 1ns/1ps
// Bypass decision.
// Does: flags an access to go around the cache when the global enable is set,
//       when the page's bit in the bypass map is set, or when it is interlocked.
// Assumes: page numbers at or above PAGES never bypass through the map.
module wt_cache_bypass_sel #(
    parameter int PAGES  = 8,
    parameter int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              byp_all,
    input  logic [PAGES-1:0]  byp_page_map,
    input  logic [PAGE_W-1:0] page,
    input  logic              lock,
    output logic              bypass
);
    logic page_hit;

    generate
        if (PAGES == 1) begin : g_single
            // With one page the map is a single bit.
            always_comb page_hit = byp_page_map[0];
        end else begin : g_multi
            // Select the page's bit; an out-of-range page selects nothing.
            always_comb begin
                page_hit = 1'b0;
                for (int p = 0; p < PAGES; p++) begin
                    if (page == PAGE_W'(p)) page_hit = byp_page_map[p];
                end
            end
        end
    endgenerate

    // Combine the three bypass causes.
    always_comb bypass = byp_all | page_hit | lock;
endmodule

// File: rtl/wt_cache_store.sv
`timescale 1ns/1ps
// Tag, valid and data store.
// Does: holds one word per line, reads combinationally, and supports fill
//       (set tag, data, valid), word update and invalidation.
// Assumes: the controller raises at most one of fill/update/invalidate per cycle.
module wt_cache_store #(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  mod_idx,
    input  logic [DATA_W-1:0] upd_data
);
    logic [LINES-1:0]  line_valid;
    logic [TAG_W-1:0]  line_tag  [LINES];
    logic [DATA_W-1:0] line_data [LINES];

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            // Valid bit: cleared on reset and invalidate, set on fill.
            always_ff @(posedge clk) begin
                if (!rst_n)                                      line_valid[i] <= 1'b0;
                else if (fill_en && fill_idx == IDX_W'(i))       line_valid[i] <= 1'b1;
                else if (inv_en && mod_idx == IDX_W'(i))         line_valid[i] <= 1'b0;
            end
            // Tag and data payload: written by fill or by a write hit.
            always_ff @(posedge clk) begin
                if (fill_en && fill_idx == IDX_W'(i)) begin
                    line_tag[i]  <= fill_tag;
                    line_data[i] <= fill_data;
                end else if (upd_en && mod_idx == IDX_W'(i)) begin
                    line_data[i] <= upd_data;
                end
            end
        end
    endgenerate

    // Combinational lookup port.
    always_comb begin
        rd_valid = line_valid[rd_idx];
        rd_tag   = line_tag[rd_idx];
        rd_data  = line_data[rd_idx];
    end

    // R7
    store_one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_en, upd_en, inv_en}));
    // R7
    inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !line_valid[$past(mod_idx)]);
endmodule

// File: rtl/wt_cache_ctrl.sv
`timescale 1ns/1ps
// Access controller.
// Does: completes read hits in place, sends all other accesses to memory as
//       one held request, updates or invalidates the line at acceptance, fills
//       on a non-bypassed read miss, and keeps the bus lock across an
//       interlocked read-modify-write.
// Assumes: the CPU holds its strobes and operands until cpu_ready and does not
//          raise read and write together; mem_ack is a one-cycle pulse.
module wt_cache_ctrl
    import wt_cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_lock,
    input  logic              bypass,
    input  logic              hit,
    input  logic [DATA_W-1:0] hit_data,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              upd_en,
    output logic              inv_en,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [DATA_W-1:0] fill_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_lock,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    ctrl_state_e       state_q;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_we, lat_byp, lat_lock;
    logic              lock_q;
    logic              is_wr, is_rd, idle, fast_hit, accept, done;

    // Decode the presented access and the completion events.
    always_comb begin
        is_wr    = cpu_wr;
        is_rd    = cpu_rd & ~cpu_wr;
        idle     = (state_q == ST_IDLE);
        fast_hit = idle & is_rd & ~bypass & hit;
        accept   = idle & (is_rd | is_wr) & ~fast_hit;
        done     = (state_q == ST_BUSY) & mem_ack;
    end

    // Line maintenance: update on write hit, invalidate on bypassed match, fill on miss.
    always_comb begin
        upd_en    = accept & is_wr & ~bypass & hit;
        inv_en    = accept & bypass & hit;
        fill_en   = done & ~lat_we & ~lat_byp;
        fill_idx  = lat_addr[IDX_W-1:0];
        fill_tag  = lat_addr[ADDR_W-1:IDX_W];
        fill_data = mem_rdata;
    end

    // CPU completion: hit data at once, otherwise memory data on acknowledge.
    always_comb begin
        cpu_ready = fast_hit | done;
        cpu_rdata = fast_hit ? hit_data : mem_rdata;
    end

    // State register: idle until an access needs memory, busy until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (accept) state_q <= ST_BUSY;
        else if (done)   state_q <= ST_IDLE;
    end

    // Request latch: freezes the memory operands for the length of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_we    <= 1'b0;
            lat_byp   <= 1'b0;
            lat_lock  <= 1'b0;
        end else if (accept) begin
            lat_addr  <= cpu_addr;
            lat_wdata <= cpu_wdata;
            lat_we    <= is_wr;
            lat_byp   <= bypass;
            lat_lock  <= cpu_lock;
        end
    end

    // Bus lock: set by an accepted interlocked read, cleared when its write is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lock_q <= 1'b0;
        else if (accept & is_rd & cpu_lock)  lock_q <= 1'b1;
        else if (done & lat_we & lat_lock)   lock_q <= 1'b0;
    end

    // Memory side outputs come from the latch.
    always_comb begin
        mem_req   = (state_q == ST_BUSY);
        mem_we    = lat_we;
        mem_addr  = lat_addr;
        mem_wdata = lat_wdata;
        mem_lock  = lock_q;
    end

    // R9
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
    // R8
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> $past(mem_ack && mem_we));
    // R4
    write_via_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !mem_req) |-> !cpu_wr);
    // R2
    hit_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !mem_req) |=> !mem_req);
endmodule

// File: rtl/wt_cache.sv
`timescale 1ns/1ps
// Direct-mapped write-through data cache with software-controlled bypass.
// Does: wires the bypass decision, the line store and the controller; the hit
//       test compares the indexed line's tag with the upper address bits.
// Assumes: word addressing; one access in flight from the CPU at a time.
module wt_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int PAGES  = 8,
    parameter int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_lock,
    input  logic [PAGE_W-1:0] cpu_page,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              byp_all,
    input  logic [PAGES-1:0]  byp_page_map,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_lock,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              bypass, hit, rd_valid;
    logic [TAG_W-1:0]  rd_tag, fill_tag;
    logic [DATA_W-1:0] rd_data, fill_data;
    logic              fill_en, upd_en, inv_en;
    logic [IDX_W-1:0]  fill_idx;

    wt_cache_bypass_sel #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_byp (
        .byp_all      (byp_all),
        .byp_page_map (byp_page_map),
        .page         (cpu_page),
        .lock         (cpu_lock),
        .bypass       (bypass)
    );

    wt_cache_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (cpu_addr[IDX_W-1:0]),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .fill_data (fill_data),
        .upd_en    (upd_en),
        .inv_en    (inv_en),
        .mod_idx   (cpu_addr[IDX_W-1:0]),
        .upd_data  (cpu_wdata)
    );

    // Tag compare for the presented address.
    always_comb hit = rd_valid && (rd_tag == cpu_addr[ADDR_W-1:IDX_W]);

    wt_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_lock  (cpu_lock),
        .bypass    (bypass),
        .hit       (hit),
        .hit_data  (rd_data),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .upd_en    (upd_en),
        .inv_en    (inv_en),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .fill_data (fill_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_lock  (mem_lock),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> !cpu_ready);
endmodule

// File: tb/wt_cache_tb.sv
`timescale 1ns/1ps
module wt_cache_tb;
    localparam int AW = 12, DW = 32, NL = 8, NP = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_rd = 0, cpu_wr = 0, cpu_lock = 0, byp_all = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [2:0]    cpu_page = '0;
    logic [NP-1:0] byp_page_map = '0;
    logic cpu_ready, mem_req, mem_we, mem_lock;
    logic mem_ack = 1'b0;
    logic [DW-1:0] cpu_rdata, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    always #10 clk = ~clk;  // 50 MHz

    wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .PAGES(NP)) u_dut (.*);

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // Reference state
    logic [DW-1:0] mem_m [4096];
    bit            m_valid [NL];
    logic [8:0]    m_tag   [NL];
    logic [DW-1:0] m_data  [NL];
    bit exp_lock = 0, busy = 0, in_hit = 0;
    int lat = 2;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder with programmable latency; also watches request stability.
    initial begin
        int cnt = 0;
        logic [AW-1:0] first_addr = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (cnt == 0) first_addr = mem_addr;
                if (cnt >= lat) begin
                    chk(mem_addr == first_addr, "R9 addr held", {20'd0, mem_addr}, {20'd0, first_addr});
                    mem_rdata = mem_m[mem_addr];
                    if (mem_we) mem_m[mem_addr] = mem_wdata;
                    mem_ack = 1'b1;
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    // Per-clock comparison against the model's lock and hit expectations.
    always @(negedge clk) begin
        #3;
        if (rst_n && !finished) begin
            if (in_hit) chk(!mem_req, "R2 no request on hit", {31'd0, mem_req}, 0);
            if (!busy) chk(mem_lock == exp_lock, "R8 lock level", {31'd0, mem_lock}, {31'd0, exp_lock});
        end
    end

    // One CPU access, checked against the reference model.
    task automatic acc(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input bit lk, input logic [2:0] pg, input string req);
        bit byp, hit, to_mem, seen = 0;
        int cyc = 0;
        logic [2:0] ix = a[2:0];
        logic [8:0] tg = a[11:3];
        logic [DW-1:0] exp_d, got_d;
        byp    = byp_all | byp_page_map[pg] | lk;
        hit    = m_valid[ix] && (m_tag[ix] == tg);
        to_mem = wr || byp || !hit;
        exp_d  = to_mem ? mem_m[a] : m_data[ix];
        @(negedge clk);
        busy = 1; in_hit = !to_mem;
        cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd; cpu_lock = lk; cpu_page = pg;
        forever begin
            #1;
            if (mem_req) begin
                seen = 1;
                if (lk) chk(mem_lock, {req, " R8 lock during request"}, {31'd0, mem_lock}, 1);
            end
            if (cpu_ready) break;
            @(negedge clk);
            cyc++;
            if (cyc > 100) break;
        end
        got_d = cpu_rdata;
        if (to_mem) begin
            chk(seen && cyc >= 1 + lat, {req, " memory access stalls"}, cyc, 1 + lat);
            chk(mem_we == wr && mem_addr == a, {req, " memory op"}, {19'd0, mem_we, mem_addr}, {19'd0, wr, a});
            if (!wr) chk(got_d == exp_d, {req, " read data"}, got_d, exp_d);
            else     chk(mem_wdata == wd, {req, " R4 write data"}, mem_wdata, wd);
        end else begin
            chk(cyc == 0 && !seen, {req, " R2 single-cycle hit"}, cyc, 0);
            chk(got_d == exp_d, {req, " R2 hit data"}, got_d, exp_d);
        end
        @(posedge clk);
        #1;
        cpu_rd = 0; cpu_wr = 0; cpu_lock = 0;
        in_hit = 0;
        if (byp && hit) m_valid[ix] = 0;
        else if (!byp && wr && hit) m_data[ix] = wd;
        else if (!byp && !wr && !hit) begin m_valid[ix] = 1; m_tag[ix] = tg; m_data[ix] = exp_d; end
        if (lk && !wr) exp_lock = 1;
        if (lk && wr)  exp_lock = 0;
        busy = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(64'd200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem_m[i] = 32'hA500_0000 ^ (i * 32'h0000_9E37);
        for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #2;
        // R1 reset state
        chk(!mem_req && !mem_lock && !cpu_ready, "R1 quiet after reset",
            {29'd0, mem_req, mem_lock, cpu_ready}, 0);

        // R3 cold miss then R2 warm hit
        acc(0, 12'h010, 0, 0, 0, "R3 cold read");
        acc(0, 12'h010, 0, 0, 0, "R2 warm read");
        // R4 write hit updates, write miss does not allocate
        acc(1, 12'h010, 32'hDEAD_0010, 0, 0, "R4 write hit");
        acc(0, 12'h010, 0, 0, 0, "R4 read after write hit");
        acc(1, 12'h123, 32'hBEEF_0123, 0, 0, "R4 write miss");
        acc(0, 12'h123, 0, 0, 0, "R4 read after write miss");
        // R10 same index, different tag evicts
        acc(0, 12'h018, 0, 0, 1, "R10 conflicting fill");
        acc(0, 12'h010, 0, 0, 0, "R10 evicted word refetch");

        // R5/R6/R7 stale data via page bypass
        lat = 0;
        acc(0, 12'h021, 0, 0, 2, "R3 fill zero latency");
        mem_m[12'h021] = 32'h1111_2222;
        acc(0, 12'h021, 0, 0, 2, "R2 stale hit");
        byp_page_map = 8'b0000_0100;
        acc(0, 12'h021, 0, 0, 2, "R5 R6 page bypass read");
        acc(0, 12'h021, 0, 0, 2, "R6 bypass does not fill");
        byp_page_map = 8'b0000_0000;
        acc(0, 12'h021, 0, 0, 2, "R7 refetch after invalidate");
        acc(0, 12'h021, 0, 0, 2, "R7 refilled hit");

        // R5 global bypass
        lat = 5;
        mem_m[12'h010] = 32'h3333_4444;
        byp_all = 1;
        acc(0, 12'h010, 0, 0, 0, "R5 global bypass read");
        byp_all = 0;
        acc(0, 12'h010, 0, 0, 0, "R7 miss after global bypass");
        // R7 bypassed write invalidates
        byp_page_map = 8'b1000_0000;
        acc(1, 12'h010, 32'h5555_6666, 0, 7, "R7 bypass write");
        byp_page_map = 8'b0000_0000;
        acc(0, 12'h010, 0, 0, 0, "R7 read after bypass write");

        // R8 interlocked read-modify-write on a cached word
        lat = 1;
        acc(0, 12'h033, 0, 0, 3, "R3 fill before lock");
        mem_m[12'h033] = 32'h7777_0001;
        acc(0, 12'h033, 0, 1, 3, "R5 R8 interlocked read");
        idle(4);
        acc(1, 12'h033, 32'h7777_0002, 1, 3, "R8 interlocked write");
        idle(2);
        acc(0, 12'h033, 0, 0, 3, "R7 read after interlocked pair");
        acc(0, 12'h033, 0, 0, 3, "R2 hit after interlocked pair");

        idle(3);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule